// File: doc/BRIEF.md
# Four-Master Pipelined Bus Arbiter

This block decides which of four bus masters may start an address phase on a shared internal bus. A single registered pointer names the master that is allowed to go next. If that master requests while the address phase is free, it is granted in the same cycle, with no added latency. Every other requester has to wait at least one cycle while the pointer is moved toward it. The grant is combinational from the requests, the address-phase-free input and the registered pointer. The next pointer is chosen among the requesters that are not being granted in the current cycle.

Each master has a 2-bit priority field, and a larger value means higher priority. The conventional setting after reset gives master 3 the value 3, master 2 the value 2, master 1 the value 1 and master 0 the value 0. The arbitration algorithm is one of two. Fixed priority ranks requesters by their field. Rotating priority ranks them by their field minus the field of the current bus master, modulo 4. With rotating priority, the master that just finished ranks lowest and every other master moves up one step.

When no candidate remains, the pointer either holds or parks on the lowest-priority master. In fixed mode, each master has a wait counter. The block falls back to rotating arbitration while any count is above a programmable threshold.

The algorithm is selected by a small state machine. It has three states:
- ST_ROTATE: rotating arbitration, entered at reset.
- ST_FIXED: fixed arbitration.
- ST_FORCED: rotating arbitration forced by starvation.

Its transitions are:
- ROTATE to FIXED when fixed mode is selected.
- FIXED to FORCED when any master is starving.
- FORCED to FIXED when no master is starving.
- Any state to ROTATE when rotating mode is selected.

Top module: `quad_bus_arbiter`

## Requirements
- R1: During reset, `ptr` is 0, the current bus master is master 0, the mode state is ST_ROTATE and all wait counts are 0. With no request, `gnt` is 0.
- R2: `gnt[i]` is 1 exactly when `addr_free` is 1, `req[i]` is 1 and `ptr` equals i, in the same cycle. At most one grant bit is ever set.
- R3: A requester not under the pointer is not granted in that cycle. If it is the only candidate, the pointer moves to it at the next clock edge, and it is granted in the following cycle.
- R4: The master granted in a cycle is excluded from that cycle's evaluation. The candidates are `req & ~gnt`.
- R5: When the algorithm is fixed and candidates exist, the next `ptr` is the candidate with the largest priority field. Ties go to the higher index. The priority field of master i is `prio[2i+1:2i]`.
- R6: When the algorithm is rotating and candidates exist, each candidate's score is `(prio_i - prio_owner) mod 4`. The next `ptr` is the candidate with the largest score, with ties going to the higher index. The owner is the master granted this cycle, or else the last master granted.
- R7: When there is no candidate, `ptr` holds if `park_low` is 0. If `park_low` is 1, `ptr` moves to the master with the smallest priority field, with ties going to the lower index.
- R8: A master's wait count increments in every cycle it requests without a grant, and saturates at 15. The count clears on a grant, and also in any cycle the master does not request.
- R9: Starving means `starve_limit` is nonzero and some wait count is greater than `starve_limit`. In ST_FIXED, starving moves the state to ST_FORCED. ST_FORCED uses rotating arbitration and returns to ST_FIXED once no master is starving. A limit of 0 never forces.
- R10: `mode_fixed` (1 means fixed, 0 means rotating) acts through the state register. A change affects the arbitration from the next cycle on, and the first cycle after reset always arbitrates by rotating priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 4 | Per-master request |
| addr_free | input | 1 | Address phase available this cycle |
| mode_fixed | input | 1 | 1 selects fixed priority, 0 selects rotating |
| park_low | input | 1 | Idle policy: 1 parks on the lowest-priority master, 0 holds the pointer |
| prio | input | 8 | Priority fields, 2 bits per master, master 0 in the low bits |
| starve_limit | input | 4 | Wait-count threshold for the fixed-mode override, 0 disables it |
| gnt | output | 4 | Per-master grant |
| ptr | output | 2 | Current arbitration pointer |

## Verification
The hardest state to reach from the ports is ST_FORCED. Reaching it takes fixed mode, a nonzero limit, and one low-priority master that keeps losing to two higher masters. Those two masters must request together, so that each one's exclusion while granted hands the pointer to the other and never to the starved master. The bench builds exactly this three-master pattern at a small limit and expects the starved master to win within a few cycles. It repeats the pattern with a zero limit and expects the starved master never to win. A cycle-accurate arithmetic model then checks every grant and pointer over a sweep of all request patterns, both values of the address-phase input, both modes, both park policies, two limits and three priority sets, one of which has duplicate fields.

// File: rtl/qarb_pkg.sv
package qarb_pkg;

    typedef enum logic [1:0] {
        ST_ROTATE = 2'd0,
        ST_FIXED  = 2'd1,
        ST_FORCED = 2'd2
    } arb_state_e;

endpackage

// File: rtl/qarb_wait_ctr.sv
module qarb_wait_ctr #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              gnt_i,
    output logic [WAIT_W-1:0] cnt_o
);

    localparam logic [WAIT_W-1:0] CNT_MAX = '1;

    logic [WAIT_W-1:0] cnt_q;

    // Count waiting cycles; a grant or a withdrawn request clears the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (gnt_i || !req_i) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/qarb_mode_fsm.sv
module qarb_mode_fsm
    import qarb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_fixed,
    input  logic starving,
    output logic use_rot
);

    arb_state_e state_q;
    arb_state_e state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ROTATE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ROTATE: begin
                if (mode_fixed) begin
                    state_d = ST_FIXED;
                end
            end
            ST_FIXED: begin
                if (!mode_fixed) begin
                    state_d = ST_ROTATE;
                end else if (starving) begin
                    state_d = ST_FORCED;
                end
            end
            ST_FORCED: begin
                if (!mode_fixed) begin
                    state_d = ST_ROTATE;
                end else if (!starving) begin
                    state_d = ST_FIXED;
                end
            end
            default: state_d = ST_ROTATE;
        endcase
    end

    // Outputs.
    always_comb begin
        unique case (state_q)
            ST_ROTATE: use_rot = 1'b1;
            ST_FIXED:  use_rot = 1'b0;
            ST_FORCED: use_rot = 1'b1;
            default:   use_rot = 1'b1;
        endcase
    end

endmodule

// File: rtl/qarb_next_sel.sv
module qarb_next_sel #(
    parameter int NUM_M = 4,
    parameter int PW    = 2
) (
    input  logic [NUM_M-1:0]    cand,
    input  logic [NUM_M*PW-1:0] prio,
    input  logic [PW-1:0]       owner,
    input  logic                use_rot,
    input  logic                park_low,
    input  logic [PW-1:0]       cur_ptr,
    output logic [PW-1:0]       nxt_ptr
);

    logic [PW-1:0] pf [NUM_M];

    for (genvar g = 0; g < NUM_M; g++) begin : g_field
        assign pf[g] = prio[g*PW +: PW];
    end

    logic [PW-1:0] own_p;
    logic [PW-1:0] score;
    logic [PW-1:0] best_sc;
    logic [PW-1:0] best_idx;
    logic [PW-1:0] low_p;
    logic [PW-1:0] low_idx;
    logic          found;

    assign own_p = pf[owner];

    // Winner scan: ">=" lets a higher index take ties; the park scan uses "<"
    // so the lowest field's lowest index wins.
    always_comb begin
        found    = 1'b0;
        best_sc  = '0;
        best_idx = '0;
        low_p    = pf[0];
        low_idx  = '0;
        score    = '0;
        for (int i = 0; i < NUM_M; i++) begin
            score = use_rot ? (pf[i] - own_p) : pf[i];
            if (cand[i] && (!found || score >= best_sc)) begin
                found    = 1'b1;
                best_sc  = score;
                best_idx = PW'(i);
            end
            if (pf[i] < low_p) begin
                low_p   = pf[i];
                low_idx = PW'(i);
            end
        end
        if (found) begin
            nxt_ptr = best_idx;
        end else if (park_low) begin
            nxt_ptr = low_idx;
        end else begin
            nxt_ptr = cur_ptr;
        end
    end

endmodule

// File: rtl/quad_bus_arbiter.sv
module quad_bus_arbiter #(
    parameter int NUM_M  = 4,
    parameter int WAIT_W = 4,
    localparam int PW    = $clog2(NUM_M)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_M-1:0]    req,
    input  logic                addr_free,
    input  logic                mode_fixed,
    input  logic                park_low,
    input  logic [NUM_M*PW-1:0] prio,
    input  logic [WAIT_W-1:0]   starve_limit,
    output logic [NUM_M-1:0]    gnt,
    output logic [PW-1:0]       ptr
);

    logic [PW-1:0]           ptr_q;
    logic [PW-1:0]           owner_q;
    logic [PW-1:0]           owner_now;
    logic [PW-1:0]           nxt_ptr;
    logic [NUM_M-1:0]        cand;
    logic [NUM_M-1:0]        over;
    logic [NUM_M*WAIT_W-1:0] wait_flat;
    logic                    starving;
    logic                    use_rot;

    for (genvar m = 0; m < NUM_M; m++) begin : g_mst
        assign gnt[m] = addr_free & req[m] & (ptr_q == PW'(m));

        qarb_wait_ctr #(.WAIT_W(WAIT_W)) u_ctr (
            .clk   (clk),
            .rst_n (rst_n),
            .req_i (req[m]),
            .gnt_i (gnt[m]),
            .cnt_o (wait_flat[m*WAIT_W +: WAIT_W])
        );

        assign over[m] = wait_flat[m*WAIT_W +: WAIT_W] > starve_limit;
    end

    assign starving  = (starve_limit != '0) && (over != '0);
    assign cand      = req & ~gnt;
    assign owner_now = (gnt != '0) ? ptr_q : owner_q;

    qarb_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_fixed (mode_fixed),
        .starving   (starving),
        .use_rot    (use_rot)
    );

    qarb_next_sel #(.NUM_M(NUM_M), .PW(PW)) u_sel (
        .cand     (cand),
        .prio     (prio),
        .owner    (owner_now),
        .use_rot  (use_rot),
        .park_low (park_low),
        .cur_ptr  (ptr_q),
        .nxt_ptr  (nxt_ptr)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            owner_q <= '0;
        end else begin
            ptr_q   <= nxt_ptr;
            owner_q <= owner_now;
        end
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/qarb_checker.sv
module qarb_checker #(
    parameter int NUM_M  = 4,
    parameter int WAIT_W = 4,
    localparam int PW    = $clog2(NUM_M)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_M-1:0]        req,
    input logic [NUM_M-1:0]        gnt,
    input logic                    addr_free,
    input logic                    park_low,
    input logic [PW-1:0]           ptr,
    input logic [NUM_M*WAIT_W-1:0] wait_flat
);

    localparam logic [WAIT_W-1:0] CNT_MAX = '1;

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt)); // R2
    AST_GNT_NEEDS_FREE: assert property (@(posedge clk) disable iff (!rst_n) (gnt != '0) |-> addr_free); // R2
    AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n) (gnt & ~req) == '0); // R2
    AST_GNT_AT_PTR: assert property (@(posedge clk) disable iff (!rst_n) (gnt != '0) |-> gnt[ptr]); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (((req & ~gnt) == '0) && !park_low) |=> $stable(ptr)); // R7

    for (genvar m = 0; m < NUM_M; m++) begin : g_chk
        logic [WAIT_W-1:0] cnt_m;
        assign cnt_m = wait_flat[m*WAIT_W +: WAIT_W];

        AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) gnt[m] |=> (cnt_m == '0)); // R8
        AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n) ((cnt_m == CNT_MAX) && req[m] && !gnt[m]) |=> (cnt_m == CNT_MAX)); // R8
    end

endmodule

bind quad_bus_arbiter qarb_checker #(.NUM_M(NUM_M), .WAIT_W(WAIT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .gnt       (gnt),
    .addr_free (addr_free),
    .park_low  (park_low),
    .ptr       (ptr),
    .wait_flat (wait_flat)
);

// File: tb/quad_bus_arbiter_tb_top.sv
`timescale 1ns/100ps
module quad_bus_arbiter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req = '0;
    logic       addr_free = 1'b0;
    logic       mode_fixed = 1'b0;
    logic       park_low = 1'b0;
    logic [1:0] pr [4];
    logic [7:0] prio_flat;
    logic [3:0] starve_limit = '0;
    logic [3:0] gnt;
    logic [1:0] ptr;

    assign prio_flat = {pr[3], pr[2], pr[1], pr[0]};

    always #2.5 clk = ~clk;

    quad_bus_arbiter dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (req),
        .addr_free    (addr_free),
        .mode_fixed   (mode_fixed),
        .park_low     (park_low),
        .prio         (prio_flat),
        .starve_limit (starve_limit),
        .gnt          (gnt),
        .ptr          (ptr)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    m_ptr, m_own, m_state;
    int    m_cnt [4];
    string last_tag = "R1";
    string force_tag = "";

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int model_next(input logic [3:0] cand, input int own);
        int best = -1;
        int bsc = 0;
        int low = 0;
        for (int i = 0; i < 4; i++) begin
            int sc;
            if (m_state != 1) sc = ((int'(pr[i]) - int'(pr[own])) % 4 + 4) % 4;
            else sc = int'(pr[i]);
            if (cand[i] && (best < 0 || sc >= bsc)) begin
                best = i;
                bsc = sc;
            end
            if (pr[i] < pr[low]) low = i;
        end
        if (best >= 0) return best;
        return park_low ? low : m_ptr;
    endfunction

    function automatic logic [3:0] model_gnt();
        return (addr_free && req[m_ptr]) ? (4'b0001 << m_ptr) : 4'b0000;
    endfunction

    task automatic drive_check(input logic [3:0] r, input logic af);
        req = r;
        addr_free = af;
        #1;
        chk("R2", "grant", int'(gnt), int'(model_gnt()));
        chk(force_tag != "" ? force_tag : last_tag, "pointer", int'(ptr), m_ptr);
    endtask

    task automatic adv();
        logic [3:0] g;
        logic [3:0] cand;
        int own_now, np, ns;
        bit starv;
        g = model_gnt();
        own_now = (g != 0) ? m_ptr : m_own;
        cand = req & ~g;
        np = model_next(cand, own_now);
        last_tag = (cand != 0) ? ((m_state != 1) ? "R6" : "R5") : "R7";
        if (m_state == 2 && cand != 0) last_tag = "R9";
        starv = 1'b0;
        for (int i = 0; i < 4; i++) if (starve_limit != 0 && m_cnt[i] > int'(starve_limit)) starv = 1'b1;
        if (!mode_fixed) ns = 0;
        else if (m_state == 0) ns = 1;
        else ns = starv ? 2 : 1;
        for (int i = 0; i < 4; i++) begin
            if (g[i] || !req[i]) m_cnt[i] = 0;
            else if (m_cnt[i] < 15) m_cnt[i] = m_cnt[i] + 1;
        end
        m_ptr = np;
        m_own = own_now;
        m_state = ns;
        @(negedge clk);
    endtask

    task automatic step(input logic [3:0] r, input logic af);
        drive_check(r, af);
        adv();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req = '0;
        addr_free = 1'b0;
        @(negedge clk);
        @(negedge clk);
        #1;
        chk("R1", "reset grant", int'(gnt), 0);
        chk("R1", "reset pointer", int'(ptr), 0);
        m_ptr = 0;
        m_own = 0;
        m_state = 0;
        for (int i = 0; i < 4; i++) m_cnt[i] = 0;
        last_tag = "R1";
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic set_prio(input int p0, input int p1, input int p2, input int p3);
        pr[0] = 2'(p0);
        pr[1] = 2'(p1);
        pr[2] = 2'(p2);
        pr[3] = 2'(p3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int seq [5];
        bit seen;
        set_prio(0, 1, 2, 3);
        do_reset();

        // R6: rotation with all masters requesting
        seq = '{0, 3, 2, 1, 0};
        for (int j = 0; j < 5; j++) begin
            drive_check(4'hF, 1'b1);
            chk("R6", "rotation grant", int'(gnt), 1 << seq[j]);
            adv();
        end

        // R3: master 1 is not under the pointer (pointer is 3)
        drive_check(4'b0010, 1'b1);
        chk("R3", "off-pointer grant", int'(gnt), 0);
        adv();
        drive_check(4'b0010, 1'b1);
        chk("R3", "grant after pointer move", int'(gnt), 4'b0010);
        adv();

        // R7: idle hold and park
        step(4'b1000, 1'b0);
        step(4'b0000, 1'b1);
        #1 chk("R7", "idle hold", int'(ptr), 3);
        park_low = 1'b1;
        step(4'b0000, 1'b1);
        #1 chk("R7", "park lowest", int'(ptr), 0);
        park_low = 1'b0;

        // R4: the granted master is excluded from evaluation
        mode_fixed = 1'b1;
        set_prio(3, 1, 2, 0);
        step(4'b0001, 1'b0);
        drive_check(4'b1001, 1'b1);
        chk("R4", "immediate grant", int'(gnt), 4'b0001);
        adv();
        #1 chk("R4", "pointer skips grantee", int'(ptr), 3);

        // R9: starvation override with limit 2
        set_prio(0, 1, 2, 3);
        starve_limit = 4'd2;
        step(4'b1000, 1'b0);
        step(4'b0000, 1'b0);
        seen = 1'b0;
        force_tag = "R9";
        for (int j = 0; j < 12; j++) begin
            drive_check(4'b1101, 1'b1);
            if (gnt[0]) seen = 1'b1;
            adv();
        end
        chk("R9", "starved master granted", int'(seen), 1);

        // R9 with limit 0, and R8 saturation over 20 waiting cycles
        starve_limit = 4'd0;
        step(4'b1000, 1'b0);
        step(4'b0000, 1'b0);
        seen = 1'b0;
        force_tag = "R8";
        for (int j = 0; j < 20; j++) begin
            drive_check(4'b1101, 1'b1);
            if (gnt[0]) seen = 1'b1;
            adv();
        end
        chk("R9", "limit zero never forces", int'(seen), 0);
        starve_limit = 4'd14;
        for (int j = 0; j < 6; j++) step(4'b1101, 1'b1);
        force_tag = "";

        // Sweep over configurations and request patterns
        for (int k = 0; k < 3; k++) begin
            if (k == 0) set_prio(0, 1, 2, 3);
            else if (k == 1) set_prio(3, 2, 1, 0);
            else set_prio(1, 1, 2, 2);
            for (int fx = 0; fx < 2; fx++) begin
                for (int pk = 0; pk < 2; pk++) begin
                    for (int li = 0; li < 2; li++) begin
                        mode_fixed = fx[0];
                        park_low = pk[0];
                        starve_limit = li ? 4'd3 : 4'd0;
                        for (int n = 0; n < 32; n++) begin
                            step(4'((n * 7 + k * 3) % 16), 1'((n / 16 + n) % 2));
                        end
                    end
                end
            end
        end

        // R10: first cycle after reset is rotating even with fixed mode selected
        mode_fixed = 1'b1;
        park_low = 1'b0;
        starve_limit = 4'd0;
        set_prio(3, 3, 2, 0);
        do_reset();
        step(4'b0110, 1'b0);
        #1 chk("R10", "first cycle rotating", int'(ptr), 2);
        step(4'b0110, 1'b0);
        #1 chk("R10", "fixed from second cycle", int'(ptr), 1);
        step(4'b0000, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule